// File: doc/BRIEF.md
# External Bus Access Sequencer

This block sits between a fast internal bus and a slower external bus that carries both address and data on the same pins. Each accepted request is sorted into one of three address regions: a register-shadow window, an emulation-memory window, or general external space. The region and the operating mode set how many bus cycles the access lasts. General external accesses in expanded modes are stretched by a per-chip-select wait count. Each bus cycle is two clock ticks long. The phase clock is high in the first tick, when the address is on the shared lines, and low in the second tick, when data moves.

Register-shadow accesses behave according to the mode. In emulation modes, writes update the internal register and are also driven onto the external bus, and reads are served from the external bus. In the other modes they touch only the internal register, and the external strobe stays idle. Reads served internally are made visible from outside: in the low phase of the final bus cycle, the internal read data is placed on the shared address lines. For a byte read, only the addressed byte lane carries data.

The internal side uses a simple handshake. `ready` stays low from the moment a request is accepted until the last bus cycle has completed. A one-cycle `done` pulse then returns the read data.

Top module: `ebus_seq`

## Requirements
- R1: A register-shadow access (address bits [22:10] all zero) lasts exactly 2 bus cycles (4 clock cycles with `ready` low) in every mode, whatever `wait_cfg` holds.
- R2: With `mode[1]`=1 (emulation), a register-shadow write pulses `reg_wr` together with `done`, and it also runs on the external bus: `ext_acc` high, `rw_n` low and `data_out` equal to the write data.
- R3: With `mode[1]`=1, a register-shadow read is an external read: `ext_acc` is high, `rw_n` stays high, `reg_wr` stays low, and `rd_data` returns `ext_data_in`.
- R4: With `mode[1]`=0, register-shadow accesses are internal only: `ext_acc` never rises and `rw_n` never falls. Writes pulse `reg_wr`, and reads return `int_rdata`.
- R5: An emulation-memory access (address bits [22:20] = 3'b100) always lasts 1 bus cycle and is never stretched.
- R6: With `mode[0]`=1 (expanded), a general external access lasts 1 + W bus cycles. W is the 2-bit field `wait_cfg[2*cs+1:2*cs]`, and cs is address bits [22:21].
- R7: With `mode[0]`=0, a general external access lasts 1 bus cycle whatever `wait_cfg` holds.
- R8: While busy, `phase_clk` is high in the first clock of each bus cycle and low in the second. `ad_out` carries address bits [15:0] in every high phase.
- R9: For an internal word read (`req_word`=1), `ad_out` equals `int_rdata` in the low phase of the final bus cycle. For every other access, `ad_out` carries the address in low phases as well.
- R10: For an internal byte read with an even address, `ad_out` = {`int_rdata`[15:8], addr[7:0]} in the final low phase. With an odd address, it is {addr[15:8], `int_rdata`[7:0]}.
- R11: `data_oe` is high, and `data_out` holds the write data, only during writes that go to the external bus. During external reads, `data_oe` stays low, leaving the data lines at high impedance.
- R12: `ready` is high when idle. It falls the cycle after a request is accepted and returns high in the same cycle as the single-cycle `done` pulse. A request presented while `ready` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Bit 1: emulation, bit 0: expanded |
| wait_cfg | input | 8 | Four 2-bit wait counts, one per chip select |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_addr | input | 23 | Request address |
| req_wdata | input | 16 | Write data |
| int_rdata | input | 16 | Data from the internal register side |
| ext_data_in | input | 16 | Data sampled from the external bus |
| ready | output | 1 | Idle, able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid with `done` |
| reg_wr | output | 1 | Internal register write strobe |
| phase_clk | output | 1 | External phase clock |
| rw_n | output | 1 | External read/write strobe, low for write |
| ext_acc | output | 1 | External bus access in progress |
| ad_oe | output | 1 | Shared address lines driven |
| ad_out | output | 16 | Shared address / visible data lines |
| data_oe | output | 1 | Data lines driven |
| data_out | output | 16 | Write data on the data lines |

## Verification
In emulation mode, a write to the register-shadow window lands in two places in the same access. The internal `reg_wr` strobe fires with `done`, while the external write shows up on `ext_acc`, `rw_n` and `data_out`. The bench issues such writes with `mode` set to 2'b11 and to 2'b00. The scoreboard then checks that both targets are hit in the first case and only the internal one in the second. A second collision is an internal read, where visible read data and the address share one set of lines in one bus cycle. Even and odd byte reads check that the data byte and the repeated address byte land in the right lanes within that final low phase.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

    typedef enum logic [1:0] {
        RGN_SHADOW = 2'd0,
        RGN_EMU    = 2'd1,
        RGN_GEN    = 2'd2
    } rgn_e;

    typedef enum logic {
        PH_HI = 1'b0,
        PH_LO = 1'b1
    } ph_e;

endpackage

// File: rtl/ebus_rgn_dec.sv
module ebus_rgn_dec
    import ebus_pkg::*;
#(
    parameter int                  ADDR_W    = 23,
    parameter int                  SHD_LSB   = 10,
    parameter logic [ADDR_W-1:0]   SHD_BASE  = '0,
    parameter int                  EMU_LSB   = 20,
    parameter logic [ADDR_W-1:0]   EMU_BASE  = 23'h400000,
    parameter int                  CS_W      = 2,
    localparam int                 HI_W      = ADDR_W - SHD_LSB
) (
    input  logic [HI_W-1:0] addr_hi,
    output rgn_e            rgn,
    output logic [CS_W-1:0] cs
);

    localparam int EMU_OFS = EMU_LSB - SHD_LSB;

    logic shd_hit;
    logic emu_hit;

    assign shd_hit = (addr_hi == SHD_BASE[ADDR_W-1:SHD_LSB]);
    assign emu_hit = (addr_hi[HI_W-1:EMU_OFS] == EMU_BASE[ADDR_W-1:EMU_LSB]);
    assign cs      = addr_hi[HI_W-1 -: CS_W];

    always_comb begin
        if (shd_hit)      rgn = RGN_SHADOW;
        else if (emu_hit) rgn = RGN_EMU;
        else              rgn = RGN_GEN;
    end

endmodule

// File: rtl/ebus_len_calc.sv
module ebus_len_calc
    import ebus_pkg::*;
#(
    parameter int  CS_W    = 2,
    parameter int  WAIT_W  = 2,
    parameter int  SHD_LEN = 2,
    localparam int NCS     = 1 << CS_W,
    localparam int MAX_LEN = 1 + (1 << WAIT_W) - 1 > SHD_LEN ? (1 << WAIT_W) : SHD_LEN,
    localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  rgn_e                    rgn,
    input  logic [CS_W-1:0]         cs,
    input  logic                    expanded,
    input  logic [NCS*WAIT_W-1:0]   wait_cfg,
    output logic [LEN_W-1:0]        len
);

    logic [WAIT_W-1:0] wfield [NCS];

    for (genvar g = 0; g < NCS; g++) begin : g_unpack
        assign wfield[g] = wait_cfg[g*WAIT_W +: WAIT_W];
    end

    always_comb begin
        unique case (rgn)
            RGN_SHADOW: len = LEN_W'(SHD_LEN);
            RGN_EMU:    len = LEN_W'(1);
            default:    len = LEN_W'(1) + (expanded ? LEN_W'(wfield[cs]) : LEN_W'(0));
        endcase
    end

endmodule

// File: rtl/ebus_vis_mux.sv
module ebus_vis_mux #(
    parameter int  DATA_W = 16,
    localparam int HALF   = DATA_W / 2
) (
    input  logic [DATA_W-1:0] addr,
    input  logic [DATA_W-1:0] rdata,
    input  logic              word,
    input  logic              show,
    output logic [DATA_W-1:0] bus
);

    always_comb begin
        bus = addr;
        if (show) begin
            if (word)         bus = rdata;
            else if (addr[0]) bus[HALF-1:0]      = rdata[HALF-1:0];
            else              bus[DATA_W-1:HALF] = rdata[DATA_W-1:HALF];
        end
    end

endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
    import ebus_pkg::*;
#(
    parameter int                ADDR_W   = 23,
    parameter int                DATA_W   = 16,
    parameter int                CS_W     = 2,
    parameter int                WAIT_W   = 2,
    parameter int                SHD_LSB  = 10,
    parameter logic [ADDR_W-1:0] SHD_BASE = '0,
    parameter int                EMU_LSB  = 20,
    parameter logic [ADDR_W-1:0] EMU_BASE = 23'h400000,
    localparam int               NCS      = 1 << CS_W,
    localparam int               MAX_LEN  = (1 << WAIT_W) > 2 ? (1 << WAIT_W) : 2,
    localparam int               LEN_W    = $clog2(MAX_LEN + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              mode,
    input  logic [NCS*WAIT_W-1:0]   wait_cfg,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic                    req_word,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    input  logic [DATA_W-1:0]       int_rdata,
    input  logic [DATA_W-1:0]       ext_data_in,
    output logic                    ready,
    output logic                    done,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    reg_wr,
    output logic                    phase_clk,
    output logic                    rw_n,
    output logic                    ext_acc,
    output logic                    ad_oe,
    output logic [DATA_W-1:0]       ad_out,
    output logic                    data_oe,
    output logic [DATA_W-1:0]       data_out
);

    typedef struct packed {
        logic              busy;
        ph_e               ph;
        logic [LEN_W-1:0]  left;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              write;
        logic              word;
        logic              ext;
        logic              intrd;
        logic              regwr;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;

    rgn_e              rgn;
    logic [CS_W-1:0]   cs;
    logic [LEN_W-1:0]  len;
    logic              emul;
    logic              expanded;
    logic              show_vis;

    assign emul     = mode[1];
    assign expanded = mode[0];

    ebus_rgn_dec #(
        .ADDR_W   (ADDR_W),
        .SHD_LSB  (SHD_LSB),
        .SHD_BASE (SHD_BASE),
        .EMU_LSB  (EMU_LSB),
        .EMU_BASE (EMU_BASE),
        .CS_W     (CS_W)
    ) rgn_dec_i (
        .addr_hi (req_addr[ADDR_W-1:SHD_LSB]),
        .rgn     (rgn),
        .cs      (cs)
    );

    ebus_len_calc #(
        .CS_W    (CS_W),
        .WAIT_W  (WAIT_W),
        .SHD_LEN (2)
    ) len_calc_i (
        .rgn      (rgn),
        .cs       (cs),
        .expanded (expanded),
        .wait_cfg (wait_cfg),
        .len      (len)
    );

    // Sequencing: each bus cycle is a high-phase tick followed by a low-phase tick.
    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (req_valid) begin
                st_d.busy  = 1'b1;
                st_d.ph    = PH_HI;
                st_d.left  = len - LEN_W'(1);
                st_d.addr  = req_addr[DATA_W-1:0];
                st_d.wdata = req_wdata;
                st_d.write = req_write;
                st_d.word  = req_word;
                st_d.ext   = (rgn == RGN_SHADOW) ? emul : 1'b1;
                st_d.intrd = (rgn == RGN_SHADOW) && !emul && !req_write;
                st_d.regwr = (rgn == RGN_SHADOW) && req_write;
            end
        end else if (st_q.ph == PH_HI) begin
            st_d.ph = PH_LO;
        end else if (st_q.left == '0) begin
            st_d.busy  = 1'b0;
            st_d.done  = 1'b1;
            st_d.rdata = st_q.intrd ? int_rdata : ext_data_in;
        end else begin
            st_d.left = st_q.left - LEN_W'(1);
            st_d.ph   = PH_HI;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign show_vis = st_q.busy && (st_q.ph == PH_LO) && (st_q.left == '0) && st_q.intrd;

    ebus_vis_mux #(
        .DATA_W (DATA_W)
    ) vis_mux_i (
        .addr  (st_q.addr),
        .rdata (int_rdata),
        .word  (st_q.word),
        .show  (show_vis),
        .bus   (ad_out)
    );

    assign ready     = !st_q.busy;
    assign done      = st_q.done;
    assign rd_data   = st_q.rdata;
    assign reg_wr    = st_q.done && st_q.regwr;
    assign phase_clk = st_q.busy && (st_q.ph == PH_HI);
    assign ext_acc   = st_q.busy && st_q.ext;
    assign rw_n      = !(st_q.busy && st_q.ext && st_q.write);
    assign ad_oe     = st_q.busy;
    assign data_oe   = st_q.busy && st_q.ext && st_q.write;
    assign data_out  = st_q.wdata;

endmodule

// File: rtl/ebus_seq_chk.sv
module ebus_seq_chk #(
    parameter int MAX_CLK = 8
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic ready,
    input logic done,
    input logic reg_wr,
    input logic phase_clk,
    input logic rw_n,
    input logic ext_acc,
    input logic data_oe,
    input logic expanded
);

    logic [7:0] busy_cnt;
    logic       exp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            exp_q    <= 1'b0;
        end else begin
            busy_cnt <= ready ? 8'd0 : busy_cnt + 8'd1;
            if (req_valid && ready) exp_q <= expanded;
        end
    end

    assert_accept_drops_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready) |=> !ready);

    assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_phase_alternates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        phase_clk |=> !phase_clk);

    assert_write_on_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rw_n |-> (data_oe && ext_acc));

    assert_regwr_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> done);

    assert_len_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && busy_cnt != 0) |-> (!busy_cnt[0] && busy_cnt >= 8'd2 && busy_cnt <= 8'(MAX_CLK)));

    assert_unstretched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && busy_cnt != 0 && !exp_q) |-> (busy_cnt <= 8'd4));

endmodule

bind ebus_seq ebus_seq_chk #(.MAX_CLK(8)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .ready     (ready),
    .done      (done),
    .reg_wr    (reg_wr),
    .phase_clk (phase_clk),
    .rw_n      (rw_n),
    .ext_acc   (ext_acc),
    .data_oe   (data_oe),
    .expanded  (mode[0])
);

// File: tb/ebus_seq_tb_top.sv
module ebus_seq_tb_top;

    localparam logic [15:0] EXT_WORD = 16'hC3A5;
    localparam logic [7:0]  WCFG     = 8'b10_01_11_00; // cs3=2, cs2=1, cs1=3, cs0=0

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [7:0]  wait_cfg = WCFG;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b1;
    logic [22:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] int_rdata = '0;
    logic [15:0] ext_data_in = EXT_WORD;
    logic        ready, done, reg_wr, phase_clk, rw_n, ext_acc, ad_oe, data_oe;
    logic [15:0] rd_data, ad_out, data_out;

    always #2.5 clk = ~clk;

    ebus_seq dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .wait_cfg(wait_cfg),
        .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
        .req_addr(req_addr), .req_wdata(req_wdata), .int_rdata(int_rdata),
        .ext_data_in(ext_data_in), .ready(ready), .done(done), .rd_data(rd_data),
        .reg_wr(reg_wr), .phase_clk(phase_clk), .rw_n(rw_n), .ext_acc(ext_acc),
        .ad_oe(ad_oe), .ad_out(ad_out), .data_oe(data_oe), .data_out(data_out)
    );

    typedef struct {
        int          clks;
        bit          ext;
        bit          wr_bus;
        bit          regwr;
        bit          is_rd;
        logic [15:0] a16;
        logic [15:0] wd;
        logic [15:0] vis;
        logic [15:0] rdata;
        string       rq;
        string       rq_vis;
    } exp_t;

    exp_t q[$];
    int   nchk = 0, nfail = 0, npush = 0, ndone = 0;

    task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic acc(logic [1:0] m, logic [22:0] a, bit wr, bit word,
                       logic [15:0] wd, logic [15:0] id, string rq, string rq_vis);
        exp_t e;
        bit shd, emu, intrd;
        @(negedge clk);
        while (!ready) @(negedge clk);
        shd   = (a[22:10] == 13'd0);
        emu   = (a[22:20] == 3'b100);
        intrd = shd && !m[1] && !wr;
        e.clks   = 2 * (shd ? 2 : emu ? 1 : 1 + (m[0] ? int'(wait_cfg[2*a[22:21] +: 2]) : 0));
        e.ext    = shd ? m[1] : 1'b1;
        e.wr_bus = e.ext && wr;
        e.regwr  = shd && wr;
        e.is_rd  = !wr;
        e.a16    = a[15:0];
        e.wd     = wd;
        if (!intrd)      e.vis = a[15:0];
        else if (word)   e.vis = id;
        else if (a[0])   e.vis = {a[15:8], id[7:0]};
        else             e.vis = {id[15:8], a[7:0]};
        e.rdata  = intrd ? id : EXT_WORD;
        e.rq     = rq;
        e.rq_vis = rq_vis;
        mode = m; req_addr = a; req_write = wr; req_word = word;
        req_wdata = wd; int_rdata = id; req_valid = 1'b1;
        q.push_back(e);
        npush++;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: gathers what the bus showed during each access and scores it at done.
    int          cnt = 0;
    bit          ph_bad = 0, addr_bad = 0, saw_ext = 0, saw_rw = 0, saw_oe = 0, dbad = 0;
    logic [15:0] lo_ad = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!ready && q.size() > 0) begin
                if (phase_clk != (cnt % 2 == 0)) ph_bad = 1;
                if (phase_clk && ad_out != q[0].a16) addr_bad = 1;
                if (!phase_clk) lo_ad = ad_out;
                if (ext_acc) saw_ext = 1;
                if (!rw_n) saw_rw = 1;
                if (data_oe) begin
                    saw_oe = 1;
                    if (data_out != q[0].wd) dbad = 1;
                end
                cnt++;
            end
            if (done) begin
                ndone++;
                if (q.size() == 0) begin
                    chk(0, "R12", "done without request", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(cnt == e.clks, e.rq, "busy clocks", cnt, e.clks);
                    chk(saw_ext == e.ext, e.rq, "ext_acc seen", saw_ext, e.ext);
                    chk(saw_rw == e.wr_bus, e.rq, "rw_n low seen", saw_rw, e.wr_bus);
                    chk(reg_wr == e.regwr, e.rq, "reg_wr at done", reg_wr, e.regwr);
                    chk(saw_oe == e.wr_bus && !dbad, "R11", "data drive", {saw_oe, dbad}, {e.wr_bus, 1'b0});
                    chk(!ph_bad, "R8", "phase clock pattern", ph_bad, 0);
                    chk(!addr_bad, "R8", "address in high phase", addr_bad, 0);
                    chk(lo_ad == e.vis, e.rq_vis, "final low phase ad_out", lo_ad, e.vis);
                    if (e.is_rd) chk(rd_data == e.rdata, e.rq, "rd_data", rd_data, e.rdata);
                end
                cnt = 0; ph_bad = 0; addr_bad = 0; saw_ext = 0; saw_rw = 0; saw_oe = 0; dbad = 0;
            end else if (reg_wr) begin
                chk(0, "R2", "reg_wr without done", 32'd1, 32'd0);
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(ready == 1'b1, "R12", "ready after reset", ready, 1);
        chk(done == 1'b0 && reg_wr == 1'b0, "R12", "done/reg_wr after reset", {done, reg_wr}, 0);
        chk(phase_clk == 1'b0, "R8", "phase_clk idle", phase_clk, 0);
        chk(rw_n == 1'b1 && ext_acc == 1'b0 && data_oe == 1'b0, "R11", "bus idle",
            {rw_n, ext_acc, data_oe}, 3'b100);

        // single-chip: register shadow internal only, visibility, wait ignored
        acc(2'b00, 23'h000012, 1, 1, 16'h5A5A, 16'h0000, "R4", "R9");
        acc(2'b00, 23'h000020, 0, 1, 16'h0000, 16'hBEEF, "R4", "R9");
        acc(2'b00, 23'h000034, 0, 0, 16'h0000, 16'h1234, "R1", "R10");
        acc(2'b00, 23'h000035, 0, 0, 16'h0000, 16'h9876, "R1", "R10");
        acc(2'b00, 23'h2000A0, 0, 1, 16'h0000, 16'h0000, "R7", "R9");
        // normal expanded: stretch per chip select, emulation memory unstretched
        acc(2'b01, 23'h0100F0, 0, 1, 16'h0000, 16'h0000, "R6", "R9");
        acc(2'b01, 23'h200044, 0, 1, 16'h0000, 16'h0000, "R6", "R9");
        acc(2'b01, 23'h600046, 0, 1, 16'h0000, 16'h0000, "R6", "R9");
        acc(2'b01, 23'h3000C2, 1, 1, 16'hA1B2, 16'h0000, "R6", "R9");
        acc(2'b01, 23'h412340, 0, 1, 16'h0000, 16'h0000, "R5", "R9");
        acc(2'b01, 23'h000200, 0, 0, 16'h0000, 16'h7E81, "R1", "R10");
        // emulation expanded: shadow write to both targets, shadow read external
        acc(2'b11, 23'h000040, 1, 1, 16'hC0DE, 16'h0000, "R2", "R9");
        acc(2'b11, 23'h000042, 0, 1, 16'h0000, 16'h4444, "R3", "R9");
        acc(2'b11, 23'h4000F8, 1, 1, 16'h0F0F, 16'h0000, "R5", "R9");
        acc(2'b11, 23'h7FFF00, 0, 1, 16'h0000, 16'h0000, "R6", "R9");
        // emulation single-chip
        acc(2'b10, 23'h0003FE, 0, 1, 16'h0000, 16'h5555, "R3", "R9");
        acc(2'b10, 23'h2000A2, 1, 0, 16'h3C3C, 16'h0000, "R7", "R9");
        acc(2'b10, 23'h0000A0, 1, 1, 16'h1111, 16'h0000, "R2", "R9");

        // R12: request during busy is ignored
        acc(2'b01, 23'h200050, 0, 1, 16'h0000, 16'h0000, "R12", "R9");
        req_valid = 1'b1; req_write = 1'b1; req_addr = 23'h000010; req_wdata = 16'hDEAD;
        @(negedge clk);
        req_valid = 1'b0;
        chk(ready == 1'b0, "R12", "ready low while busy", ready, 0);

        @(negedge clk);
        while (!ready || q.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(ndone == npush, "R12", "one done per accepted request", ndone, npush);
        chk(q.size() == 0, "R12", "scoreboard drained", q.size(), 0);
        finish_run();
    end

endmodule